// File: doc/BRIEF.md
# Four-Lane Seven-to-One Deserializer with Failsafe

This block rebuilds 28-bit parallel words from four serial data lanes and one framing lane. A sampling clock at the serial bit rate comes from outside the block. On every bit clock the block samples one bit from each data lane and one bit from the framing lane. The framing lane repeats a fixed seven-bit shape once per word. The block finds the word boundary from that shape, collects seven bits per lane, and presents the assembled word with an output word clock. The rising edge of the word clock falls in the middle of each stable word.

Three conditions control what the outputs show. While the active-low powerdown input is low, the data outputs are driven low and alignment is dropped. Data lanes that sit idle at a high level, while the framing lane still toggles, come out as all ones. If the framing lane stops, the block keeps the last good word on the data outputs and holds the word clock high until framing returns and lock is found again.

Top module: `link_deser`

## Requirements
- R1: Within a word period, slot s (s = 0 is the first bit in time, s = 6 the last) of data lane L (bit L of `data_lanes`) appears on `word_out` bit 7*L + s.
- R2: A word period is the seven bit clocks in which `clk_lane` carries 1,1,0,0,0,1,1 in slots 0 to 6. The slot-6 bits are taken at the same clock edge that completes this shape.
- R3: `locked` rises at the end of the third consecutive frame that ends at the expected slot. A frame that does not end on the expected slot (a bit slip) drops `locked`, and the count of good frames restarts from the new boundary.
- R4: `word_out` changes only at frame-end edges while the block is locked. The word received in frame k appears on `word_out` at the end of frame k+1, so the latency is two word periods from its first bit.
- R5: After each frame end `word_clk` is low for 3 bit clocks and then high for 4, so it rises 3 bit clocks after the data changes.
- R6: While `pwr_n` is low, `word_out` and `word_clk` are 0 and `locked` is cleared. After release, `word_out` stays 0 until lock is regained; it then shows the second frame received after release.
- R7: Data lanes held high while framing continues produce an all-ones `word_out`.
- R8: After 14 bit clocks with no rising edge on `clk_lane`, `word_clk` is held high and `word_out` keeps the last word presented. After the framing lane returns, the block relocks as in R3.
- R9: While reset is asserted, `word_out`, `word_clk` and `locked` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_n | input | 1 | Active-low powerdown |
| clk_lane | input | 1 | Serial framing lane, sampled each bit clock |
| data_lanes | input | 4 | Serial data lanes, one bit per lane each bit clock |
| word_out | output | 28 | Rebuilt parallel word |
| word_clk | output | 1 | Word strobe, rises mid-word |
| locked | output | 1 | High after three aligned frames |

## Verification
The assertions assume that `clk_lane` and `data_lanes` change only between sampling edges, one bit per clock. They also assume that `pwr_n` changes away from the clock edge. The word-clock property assumes that a rise of the strobe is not caused by a release of powerdown or of the missing-clock state. The stimulus drives every input on the falling clock edge. It places bit slips and stuck framing only at frame boundaries, so the assumed input shape always holds. Inserted idle cycles are limited to two zeros, so they cannot by themselves form a false framing shape.

// File: rtl/link_deser.sv
module link_deser #(
  parameter int LANES = 4,
  parameter int MISS_LIM = 14,
  parameter logic [6:0] FRAME_PAT = 7'b1100011
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pwr_n,
  input  logic                 clk_lane,
  input  logic [LANES-1:0]     data_lanes,
  output logic [7*LANES-1:0]   word_out,
  output logic                 word_clk,
  output logic                 locked
);
  localparam int W  = 7 * LANES;
  localparam int MW = $clog2(MISS_LIM + 1);

  logic [5:0]    chist;
  logic [5:0]    dsh [LANES];
  logic [2:0]    ph;
  logic [1:0]    good;
  logic [MW-1:0] quiet;
  logic [W-1:0]  asm_w, cap, word_q;
  logic          det, fend, missing, rise;

  assign det     = ({chist, clk_lane} == FRAME_PAT);
  assign fend    = det && (ph == 3'd6);
  assign rise    = clk_lane & ~chist[0];
  assign missing = (quiet == MISS_LIM[MW-1:0]);

  genvar gl, gs;
  generate
    for (gl = 0; gl < LANES; gl++) begin : g_lane
      for (gs = 0; gs < 6; gs++) begin : g_slot
        assign asm_w[7*gl+gs] = dsh[gl][5-gs];
      end
      assign asm_w[7*gl+6] = data_lanes[gl];
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) dsh[gl] <= '0;
        else        dsh[gl] <= {dsh[gl][4:0], data_lanes[gl]};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chist  <= '0;
      ph     <= '0;
      good   <= '0;
      quiet  <= '0;
      cap    <= '0;
      word_q <= '0;
    end else begin
      chist <= {chist[4:0], clk_lane};
      if (det)             ph <= '0;
      else if (ph == 3'd6) ph <= '0;
      else                 ph <= ph + 3'd1;
      if (!pwr_n)          good <= '0;
      else if (det)        good <= fend ? ((good == 2'd3) ? 2'd3 : good + 2'd1) : 2'd1;
      else if (ph == 3'd6) good <= '0;
      if (rise)            quiet <= '0;
      else if (!missing)   quiet <= quiet + 1'b1;
      if (fend) cap <= asm_w;
      if (!pwr_n)                             word_q <= '0;
      else if (fend && good >= 2'd2 && !missing) word_q <= cap;
    end
  end

  assign locked   = (good == 2'd3);
  assign word_out = pwr_n ? word_q : '0;
  assign word_clk = pwr_n & (missing | (ph >= 3'd3));

  // R6
  pwrdn_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_n |=> !locked);
  // R4
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_n && !fend) |=> (!pwr_n || $stable(word_out)));
  // R8
  miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (missing && pwr_n) |=> $stable(word_q));
  // R3
  lock_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> (ph == 3'd0));
  // R5
  wclk_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(word_clk) && !missing && $past(pwr_n) && !$past(missing)) |-> (ph == 3'd3));
endmodule

// File: tb/link_deser_tb.sv
module link_deser_tb_top;
  logic clk = 0, rst_n = 0, pwr_n = 1, clk_lane = 0;
  logic [3:0]  data_lanes = '0;
  logic [27:0] word_out;
  logic        word_clk, locked;
  int n_chk = 0, n_err = 0;
  bit chk_wclk = 0, done = 0;
  localparam logic [6:0] PAT = 7'b1100011;

  link_deser dut_i (.clk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .clk_lane(clk_lane),
    .data_lanes(data_lanes), .word_out(word_out), .word_clk(word_clk), .locked(locked));

  always #4 clk = ~clk;

  task automatic chk(input string r, input logic [27:0] a, input logic [27:0] e);
    n_chk++;
    if (a !== e) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", r, a, e);
    end
  endtask

  task automatic send(input logic [27:0] w, input logic [6:0] pat);
    for (int s = 0; s < 7; s++) begin
      @(negedge clk);
      clk_lane = pat[6-s];
      for (int l = 0; l < 4; l++) data_lanes[l] = w[7*l+s];
      @(posedge clk); #1;
      if (chk_wclk) chk("R5 word_clk", {27'd0, word_clk}, {27'd0, ((s+1)%7) >= 3});
    end
  endtask

  initial begin
    logic [27:0] prev, held;
    logic [31:0] x;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 word_out", word_out, '0);
    chk("R9 locked", {27'd0, locked}, '0);
    chk("R9 word_clk", {27'd0, word_clk}, '0);
    @(negedge clk) rst_n = 1;

    send(28'h0A0B0C0, PAT);
    chk("R3 locked after 1", {27'd0, locked}, '0);
    send(28'h5A5A5A5, PAT);
    chk("R3 locked after 2", {27'd0, locked}, '0);
    chk("R4 not yet", word_out, '0);
    send(28'h1234567, PAT);
    chk("R3 locked after 3", {27'd0, locked}, 28'd1);
    chk("R4 latency", word_out, 28'h5A5A5A5);

    prev = 28'h1234567;
    chk_wclk = 1;
    for (int k = 0; k < 28; k++) begin
      send(28'd1 << k, PAT);
      chk("R1 walking bit", word_out, prev);
      prev = 28'd1 << k;
    end
    x = 32'h1F2E3D4C;
    for (int k = 0; k < 12; k++) begin
      x = x * 32'd1103515245 + 32'd12345;
      send(x[27:0], PAT);
      chk("R2 pattern word", word_out, prev);
      prev = x[27:0];
    end
    chk_wclk = 0;

    send('1, PAT);
    send('1, PAT);
    chk("R7 idle lanes ones", word_out, '1);
    chk("R5 low after frame end", {27'd0, word_clk}, '0);

    held = word_out;
    send(28'h0F0F0F0, 7'd0);
    chk("R8 not yet missing", {27'd0, word_clk}, '0);
    chk("R8 hold 1", word_out, held);
    send(28'h3C3C3C3, 7'd0);
    chk("R8 clock held high", {27'd0, word_clk}, 28'd1);
    chk("R8 hold 2", word_out, held);
    chk("R8 unlocked", {27'd0, locked}, '0);
    send(28'h0000FFF, 7'd0);
    chk("R8 hold 3", word_out, held);
    send(28'h1111111, PAT);
    chk("R8 clock released", {27'd0, word_clk}, '0);
    send(28'h2222222, PAT);
    chk("R8 hold during relock", word_out, held);
    send(28'h3333333, PAT);
    chk("R8 relocked", {27'd0, locked}, 28'd1);
    chk("R8 new word", word_out, 28'h2222222);

    repeat (2) begin
      @(negedge clk); clk_lane = 0; data_lanes = '0;
      @(posedge clk);
    end
    #1;
    send(28'h4444444, PAT);
    chk("R3 slip unlocks", {27'd0, locked}, '0);
    chk("R4 slip hold", word_out, 28'h2222222);
    send(28'h5555555, PAT);
    chk("R3 slip count 2", {27'd0, locked}, '0);
    send(28'h6666666, PAT);
    chk("R3 slip relock", {27'd0, locked}, 28'd1);
    chk("R3 slip word", word_out, 28'h5555555);

    @(negedge clk) pwr_n = 0;
    #1;
    chk("R6 data low", word_out, '0);
    chk("R6 clock low", {27'd0, word_clk}, '0);
    send(28'h7777777, PAT);
    send(28'h0888888, PAT);
    chk("R6 unlocked", {27'd0, locked}, '0);
    chk("R6 data low 2", word_out, '0);
    @(negedge clk) pwr_n = 1;
    send(28'h0999999, PAT);
    chk("R6 zero after release", word_out, '0);
    send(28'h0AAAAAA, PAT);
    chk("R6 zero before lock", word_out, '0);
    send(28'h0BBBBBB, PAT);
    chk("R6 relocked", {27'd0, locked}, 28'd1);
    chk("R6 word after relock", word_out, 28'h0AAAAAA);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule